// File: doc/BRIEF.md
# Serial EEPROM Command and Page Controller

This block sits behind a two-wire serial slave front-end. The front-end turns bus activity into single-cycle events: a START, a STOP, a data bit clocked in, a complete received byte, a request for the next read byte, and the master's acknowledge bit after a read byte. The controller decides whether each received byte is acknowledged. It keeps a 16-bit address pointer and returns read bytes from two places: an inferred byte array and a separate 64-byte identification page. That page can be locked once.

Writes are collected in a 64-byte page buffer. They commit only during a timed internal write cycle, and that cycle starts only when the STOP arrives cleanly after an acknowledged data byte. While the cycle runs the block reports busy and refuses new select bytes, so a host can poll for completion. A write-protect input refuses data bytes but still lets addressing proceed, so reads that follow a dummy write work normally. The array size is set by `MEM_AW`: 11 gives 2K bytes, and 15 gives the full 32K.

Top module: `ee_cmd_ctrl`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 are 1010 (array) or 1011 (ID space), bits 3:1 equal `strap_id`, and the block is not busy. Bit 0 is 1 for read and 0 for write. Any other select is nacked, and every later byte up to the next START is nacked.
- R2: After a write select, two address bytes follow, high byte first, and both are acknowledged. The array uses only the low `MEM_AW` pointer bits, so bit 15 has no effect.
- R3: Each accepted data byte goes to the current offset inside its 64-byte page, and only the low 6 pointer bits advance. Bytes past the page end therefore overwrite the start of the same page.
- R4: While `wr_protect` is 1, select and address bytes are acknowledged, every data byte is nacked, no write cycle starts and memory is unchanged.
- R5: A write cycle starts only on a STOP that comes after an acknowledged data byte with no bit clocked in between. Any other STOP leaves memory unchanged and starts no cycle.
- R6: `busy` rises in the cycle after a qualifying STOP and stays high for exactly `WR_CYCLES` cycles. Select bytes are nacked while it is high.
- R7: After a completed write, a current-address read returns the byte that follows the last written byte within its page.
- R8: A read returns the byte at the pointer. The pointer advances at each master acknowledge slot and wraps from the top array address to 0. A master nack ends the read, and after it no read byte is returned until the next START.
- R9: Type 1011 with address bit 10 = 0 addresses the ID page at offset A5..A0. After reset, ID offsets 0, 1 and 2 hold 20h, E0h and 0Fh, and all other offsets hold FFh.
- R10: A lock command uses type 1011, address bit 10 = 1 and a single data byte with bit 1 set. Such a byte is acknowledged, and the lock takes effect in the write cycle. A lock byte with bit 1 clear is nacked. Once the page is locked, ID data bytes and further lock bytes are nacked until reset.
- R11: An ID-space read with address bit 10 = 1 returns 01h when the page is locked and 00h when it is not.
- R12: After reset, `busy`, `ack_valid` and `tx_valid` are 0.
- R13: `ack_valid` pulses in the cycle after each `rx_valid`. `tx_valid` pulses in the cycle after a `tx_req` in the read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_id | input | 3 | Board-strapped device address bits |
| wr_protect | input | 1 | 1 refuses all data-byte writes |
| ev_start | input | 1 | START or repeated START seen |
| ev_stop | input | 1 | STOP seen |
| bit_clk | input | 1 | A bit of a new byte was clocked in |
| rx_valid | input | 1 | A received byte is available |
| rx_byte | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 acknowledges, 0 nacks |
| tx_req | input | 1 | Front-end asks for the next read byte |
| tx_valid | output | 1 | Read byte is valid |
| tx_byte | output | 8 | Read byte |
| mack_valid | input | 1 | Master acknowledge slot after a read byte |
| mack_ok | input | 1 | 1 when the master acknowledged |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Two functions can collide on the same bus slot. A new select byte can arrive while the write cycle triggered by the previous STOP is still running, and a STOP can land on a bit boundary that is not the one right after a data acknowledge. The bench covers both. It polls with a select right after the triggering STOP and expects a nack. It also clocks one extra bit after a data acknowledge before the STOP, and then checks through a read that the array was left unchanged. `busy` is compared on every clock against a behavioural countdown that the bench model starts at each qualifying STOP.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam int PAGE_AW    = 6;
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam logic [3:0] TYPE_ARR = 4'hA;
    localparam logic [3:0] TYPE_IDP = 4'hB;

    typedef enum logic [2:0] {
        S_IDLE, S_SEL, S_AHI, S_ALO, S_WDATA, S_RDATA, S_IGN
    } st_e;

    typedef enum logic [1:0] {
        WK_ARRAY, WK_ID, WK_LOCK
    } wk_e;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] strap);
        return ((b[7:4] == TYPE_ARR) || (b[7:4] == TYPE_IDP)) && (b[3:1] == strap);
    endfunction

    function automatic logic [15:0] page_next(input logic [15:0] p);
        return {p[15:PAGE_AW], p[PAGE_AW-1:0] + 1'b1};
    endfunction

    function automatic logic [7:0] id_init(input int idx);
        case (idx)
            0:       return 8'h20;
            1:       return 8'hE0;
            2:       return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/ee_page_buf.sv
module ee_page_buf
    import ee_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               we,
    input  logic [PAGE_AW-1:0] waddr,
    input  logic [7:0]         wdata,
    input  logic [PAGE_AW-1:0] raddr,
    output logic [7:0]         rdata,
    output logic               rvld
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q[waddr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) data_q[waddr] <= wdata;
    end

    assign rdata = data_q[raddr];
    assign rvld  = mask_q[raddr];
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
    parameter int WR_CYCLES = 80,
    localparam int CW = $clog2(WR_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    output logic          busy,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(WR_CYCLES - 1)) busy <= 1'b0;
            else                           cnt  <= cnt + 1'b1;
        end
    end

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != CW'(WR_CYCLES - 1)) |=> busy);
    // R6
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));
endmodule

// File: rtl/ee_cmd_ctrl.sv
module ee_cmd_ctrl
    import ee_pkg::*;
#(
    parameter int MEM_AW    = 11,
    parameter int WR_CYCLES = 80,
    localparam int MEM_BYTES = 1 << MEM_AW,
    localparam int CW        = $clog2(WR_CYCLES)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] strap_id,
    input  logic       wr_protect,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       bit_clk,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    output logic       ack_valid,
    output logic       ack_ok,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       mack_valid,
    input  logic       mack_ok,
    output logic       busy
);
    st_e         st;
    wk_e         kind;
    logic [15:0] ptr;
    logic        sel_id, have_data, slot_clean, locked;
    logic [7:0]  id_pg [PAGE_BYTES];
    logic [7:0]  mem   [MEM_BYTES];

    logic          go, sel_hit, acc, buf_clr, buf_we, buf_vld, commit;
    logic [7:0]    buf_data, rd_mux;
    logic [CW-1:0] tcnt;
    logic [15:0]   arr_next;

    ee_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(go), .busy(busy), .cnt(tcnt)
    );

    ee_page_buf u_buf (
        .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we),
        .waddr(ptr[PAGE_AW-1:0]), .wdata(rx_byte),
        .raddr(tcnt[PAGE_AW-1:0]), .rdata(buf_data), .rvld(buf_vld)
    );

    always_comb begin
        sel_hit = sel_match(rx_byte, strap_id) && !busy;
        case (kind)
            WK_ARRAY: acc = !wr_protect;
            WK_ID:    acc = !wr_protect && !locked;
            default:  acc = !wr_protect && !locked && !have_data && rx_byte[1];
        endcase
        buf_clr = (st == S_SEL) && rx_valid && sel_hit && !rx_byte[0];
        buf_we  = (st == S_WDATA) && rx_valid && acc;
        go      = ev_stop && (st == S_WDATA) && slot_clean && have_data && !busy;
        commit  = busy && (tcnt < CW'(PAGE_BYTES)) && buf_vld;
        arr_next = ptr;
        arr_next[MEM_AW-1:0] = ptr[MEM_AW-1:0] + 1'b1;
        if (sel_id) rd_mux = ptr[10] ? {7'b0, locked} : id_pg[ptr[PAGE_AW-1:0]];
        else        rd_mux = mem[ptr[MEM_AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (commit && kind == WK_ARRAY)
            mem[{ptr[MEM_AW-1:PAGE_AW], tcnt[PAGE_AW-1:0]}] <= buf_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            kind       <= WK_ARRAY;
            ptr        <= '0;
            sel_id     <= 1'b0;
            have_data  <= 1'b0;
            slot_clean <= 1'b0;
            locked     <= 1'b0;
            ack_valid  <= 1'b0;
            ack_ok     <= 1'b0;
            tx_valid   <= 1'b0;
            tx_byte    <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) id_pg[i] <= id_init(i);
        end else begin
            ack_valid <= rx_valid;
            ack_ok    <= 1'b0;
            tx_valid  <= 1'b0;
            if (commit && kind == WK_ID) id_pg[tcnt[PAGE_AW-1:0]] <= buf_data;
            if (busy && tcnt == '0 && kind == WK_LOCK) locked <= 1'b1;
            if (ev_start) begin
                st <= S_SEL;
            end else if (ev_stop) begin
                st <= S_IDLE;
            end else begin
                case (st)
                    S_SEL: if (rx_valid) begin
                        if (sel_hit) begin
                            ack_ok <= 1'b1;
                            sel_id <= (rx_byte[7:4] == TYPE_IDP);
                            st     <= rx_byte[0] ? S_RDATA : S_AHI;
                        end else begin
                            st <= S_IGN;
                        end
                    end
                    S_AHI: if (rx_valid) begin
                        ack_ok     <= 1'b1;
                        ptr[15:8]  <= rx_byte;
                        st         <= S_ALO;
                    end
                    S_ALO: if (rx_valid) begin
                        ack_ok     <= 1'b1;
                        ptr[7:0]   <= rx_byte;
                        kind       <= !sel_id ? WK_ARRAY : (ptr[10] ? WK_LOCK : WK_ID);
                        have_data  <= 1'b0;
                        slot_clean <= 1'b0;
                        st         <= S_WDATA;
                    end
                    S_WDATA: begin
                        if (bit_clk) slot_clean <= 1'b0;
                        if (rx_valid) begin
                            if (acc) begin
                                ack_ok     <= 1'b1;
                                ptr        <= page_next(ptr);
                                have_data  <= 1'b1;
                                slot_clean <= 1'b1;
                            end else begin
                                slot_clean <= 1'b0;
                            end
                        end
                    end
                    S_RDATA: begin
                        if (tx_req) begin
                            tx_valid <= 1'b1;
                            tx_byte  <= rd_mux;
                        end
                        if (mack_valid) begin
                            ptr <= sel_id ? page_next(ptr) : arr_next;
                            if (!mack_ok) st <= S_IGN;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    busy_sel_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_SEL && rx_valid && busy && !ev_start && !ev_stop) |=> (ack_valid && !ack_ok));
    // R4
    wp_data_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_WDATA && rx_valid && wr_protect) |=> !ack_ok);
    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> locked);
    // R13
    ack_timing_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(rx_valid));
    // R5
    stop_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ev_stop));
endmodule

// File: tb/ee_cmd_ctrl_test.sv
module ee_cmd_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 11;
    localparam int WRC  = 80;
    localparam int MASK = (1 << AW) - 1;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_protect = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, bit_clk = 1'b0;
    logic rx_valid = 1'b0, tx_req = 1'b0, mack_valid = 1'b0, mack_ok = 1'b0;
    logic [7:0] rx_byte = '0;
    logic ack_valid, ack_ok, tx_valid, busy;
    logic [7:0] tx_byte;

    int checks = 0, errors = 0, mb_left = 0, pref = 0;
    bit lkref = 0;
    logic [7:0] mref [int];
    logic [7:0] idref [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    ee_cmd_ctrl #(.MEM_AW(AW), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .strap_id(STRAP), .wr_protect(wr_protect),
        .ev_start(ev_start), .ev_stop(ev_stop), .bit_clk(bit_clk),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .ack_valid(ack_valid), .ack_ok(ack_ok),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .mack_valid(mack_valid), .mack_ok(mack_ok), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R6: busy compared with the model countdown on every clock
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk(busy === (mb_left > 0), "R6 busy", busy, mb_left > 0);
            if (mb_left > 0) mb_left--;
        end
    end

    task automatic start_c();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic stop_c(input bit trig);
        @(negedge clk); ev_stop = 1'b1; if (trig) mb_left = WRC;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic bit_c();
        @(negedge clk); bit_clk = 1'b1;
        @(negedge clk); bit_clk = 1'b0;
    endtask

    task automatic byte_c(input logic [7:0] b, input bit exp, input string tag);
        bit_c();
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk(ack_valid === 1'b1 && ack_ok === exp, tag, {ack_valid, ack_ok}, {1'b1, exp});
    endtask

    task automatic rd_c(input logic [7:0] exp, input bit mack, input string tag);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        chk(tx_valid === 1'b1 && tx_byte === exp, tag, tx_byte, exp);
        mack_valid = 1'b1; mack_ok = mack;
        @(negedge clk); mack_valid = 1'b0;
    endtask

    task automatic wr_cmd(input bit idsp, input int addr, input logic [7:0] d[$],
                          input bit good_stop, input string tag);
        bit sel_ack, acc, any_acc, last_acc;
        int kind, off;
        int offs[$];
        logic [7:0] vals[$];
        start_c();
        sel_ack = (mb_left == 0);
        byte_c({idsp ? 4'hB : 4'hA, STRAP, 1'b0}, sel_ack, {tag, " R1 select"});
        if (!sel_ack) begin stop_c(0); return; end
        byte_c(addr[15:8], 1'b1, {tag, " R2 addr hi"});
        byte_c(addr[7:0],  1'b1, {tag, " R2 addr lo"});
        pref = addr;
        kind = !idsp ? 0 : (addr[10] ? 2 : 1);
        any_acc = 0; last_acc = 0;
        foreach (d[i]) begin
            if (wr_protect) acc = 0;
            else if (kind == 0) acc = 1;
            else if (kind == 1) acc = !lkref;
            else acc = !lkref && !any_acc && d[i][1];
            byte_c(d[i], acc, {tag, " data"});
            last_acc = acc;
            if (acc) begin
                any_acc = 1;
                offs.push_back(pref & 63);
                vals.push_back(d[i]);
                pref = (pref & ~63) | ((pref + 1) & 63);
            end
        end
        if (!good_stop) bit_c();
        stop_c(good_stop && last_acc);
        if (good_stop && last_acc) begin
            foreach (offs[i]) begin
                off = offs[i];
                if (kind == 0) mref[(addr & MASK & ~63) | off] = vals[i];
                else if (kind == 1) idref[off] = vals[i];
                else lkref = 1;
            end
        end
    endtask

    task automatic rd_cmd(input bit idsp, input int n, input string tag);
        logic [7:0] exp;
        start_c();
        byte_c({idsp ? 4'hB : 4'hA, STRAP, 1'b1}, mb_left == 0, {tag, " R1 read select"});
        for (int i = 0; i < n; i++) begin
            if (idsp) exp = pref[10] ? {7'b0, lkref} : idref[pref & 63];
            else      exp = mref[pref & MASK];
            rd_c(exp, i < n - 1, tag);
            if (idsp) pref = (pref & ~63) | ((pref + 1) & 63);
            else      pref = (pref & ~MASK) | ((pref + 1) & MASK);
        end
        stop_c(0);
    endtask

    task automatic rand_rd(input bit idsp, input int addr, input int n, input string tag);
        start_c();
        byte_c({idsp ? 4'hB : 4'hA, STRAP, 1'b0}, 1'b1, {tag, " R1 dummy select"});
        byte_c(addr[15:8], 1'b1, {tag, " R2 addr hi"});
        byte_c(addr[7:0],  1'b1, {tag, " R2 addr lo"});
        pref = addr;
        rd_cmd(idsp, n, tag);
    endtask

    task automatic wait_idle();
        while (mb_left > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) idref[i] = (i == 0) ? 8'h20 : (i == 1) ? 8'hE0 : (i == 2) ? 8'h0F : 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && ack_valid === 1'b0 && tx_valid === 1'b0, "R12 reset outputs",
            {busy, ack_valid, tx_valid}, 0);

        // R9 identification defaults through a sequential ID read
        rand_rd(1, 16'h0000, 4, "R9 id defaults");

        // R2 bit 15 ignored; R6 polling while busy is nacked
        wr_cmd(0, 16'h8123, '{8'h5A}, 1, "R2 byte write");
        start_c();
        byte_c({4'hA, STRAP, 1'b0}, 1'b0, "R6 poll nack while busy");
        stop_c(0);
        wait_idle();
        rand_rd(0, 16'h0123, 1, "R2 read back");

        // R3 page roll-over, R7 current-address read after write
        wr_cmd(0, 16'h01C2, '{8'h77}, 1, "R3 seed");
        wait_idle();
        wr_cmd(0, 16'h01FE, '{8'h11, 8'h22, 8'h33, 8'h44}, 1, "R3 page write");
        wait_idle();
        rd_cmd(0, 1, "R7 current address");
        rand_rd(0, 16'h01FE, 2, "R3 page tail");
        rand_rd(0, 16'h01C0, 3, "R3 rolled head");

        // R4 write protect
        wr_protect = 1'b1;
        wr_cmd(0, 16'h0123, '{8'hA5, 8'hA6}, 1, "R4 protected");
        wr_protect = 1'b0;
        rand_rd(0, 16'h0123, 1, "R4 unchanged");

        // R5 STOP not in the slot after a data acknowledge
        wr_cmd(0, 16'h0123, '{8'hC3}, 0, "R5 late stop");
        rand_rd(0, 16'h0123, 1, "R5 unchanged");

        // R8 sequential wrap across the array top, and end on master nack
        wr_cmd(0, MASK, '{8'hEE}, 1, "R8 seed top");
        wait_idle();
        wr_cmd(0, 16'h0000, '{8'hDD}, 1, "R8 seed zero");
        wait_idle();
        rand_rd(0, MASK, 2, "R8 wrap");
        start_c();
        byte_c({4'hA, STRAP, 1'b1}, 1'b1, "R8 select");
        rd_c(mref[pref & MASK], 1'b0, "R8 single");
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        chk(tx_valid === 1'b0, "R8 no byte after master nack", tx_valid, 0);
        stop_c(0);

        // R1 mismatched strap and type
        start_c();
        byte_c({4'hA, 3'b010, 1'b0}, 1'b0, "R1 wrong strap");
        byte_c(8'h00, 1'b0, "R1 ignored after mismatch");
        stop_c(0);
        start_c();
        byte_c({4'h5, STRAP, 1'b1}, 1'b0, "R1 wrong type");
        stop_c(0);

        // R9 ID page write
        wr_cmd(1, 16'h0005, '{8'h99}, 1, "R9 id write");
        wait_idle();
        rand_rd(1, 16'h0005, 2, "R9 id read");

        // R10 / R11 lock flow
        wr_cmd(1, 16'h0400, '{8'h01}, 1, "R10 lock bit clear");
        rand_rd(1, 16'h0400, 1, "R11 status unlocked");
        wr_cmd(1, 16'h0400, '{8'h02}, 1, "R10 lock");
        wait_idle();
        rand_rd(1, 16'h0400, 1, "R11 status locked");
        wr_cmd(1, 16'h0006, '{8'h55}, 1, "R10 write after lock");
        rand_rd(1, 16'h0005, 2, "R10 id unchanged");
        wr_cmd(1, 16'h0400, '{8'h02}, 1, "R10 relock nacked");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule